// File: doc/BRIEF.md
# NAND Page Hamming ECC Accumulator

This block builds a single-error-correcting Hamming parity word over the bytes that pass between a host and a NAND device. It works on fixed chunks of 256 bytes. Each accepted byte adds its share to a set of line-parity bits, which come from the XOR of the byte's bits and its index inside the chunk. It also folds the byte into a running column XOR, from which the column-parity bits come. The same logic serves page reads and page writes, because only the byte stream matters.

When the last byte of a chunk is accepted, the finished parity word moves into a holding register. The block pulses a done strobe and starts the next chunk at once, so back-to-back chunks lose no cycle. The held word is also offered in the form stored in the spare area: shifted left by two, inverted to 24 bits, with the first stored byte in the top eight bits. A clear pulse restarts accumulation before a transfer. A valid flag tells the host when the held code may be read.

Top module: `nand_ecc_accum`

## Requirements
- R1: After reset, `parityWord` is 0, and `chunkDone` and `codeValid` are low.
- R2: A byte is accepted only at a clock edge where `byteValid` and `eccEn` are both high and `clrPulse` is low. Other bytes change neither the parity nor the chunk byte count.
- R3: `chunkDone` is high for exactly one cycle, right after the edge that accepts the 256th byte of a chunk. `parityWord` takes the completed chunk's parity at that same edge.
- R4: Column parity sits in `parityWord[5:0]`. For j in 0..2, bit 2j is the XOR of all data bits whose bit position has bit j clear, and bit 2j+1 is the XOR of those whose position has bit j set.
- R5: Line parity sits in `parityWord[21:6]`. For k in 0..7, bit 6+2k is the XOR of the byte parities of bytes whose chunk index has bit k clear, and bit 7+2k is the XOR for bytes whose index has bit k set.
- R6: The accumulator restarts at the chunk boundary, so each chunk's parity depends only on that chunk's 256 bytes.
- R7: `clrPulse` empties the running parity and the byte count and drops `codeValid`. A byte offered in the same cycle is dropped. `parityWord` keeps its value.
- R8: `codeBytes` equals the bitwise inverse of `{parityWord, 2'b00}`. Bits 23:16 are the first stored byte, 15:8 the second and 7:0 the third.
- R9: `codeValid` rises together with `chunkDone` and stays high until a clear. Between chunk ends, `parityWord` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| eccEn | input | 1 | Accumulation enable |
| clrPulse | input | 1 | Synchronous clear of running parity and count |
| byteValid | input | 1 | Byte strobe |
| byteData | input | 8 | Data byte |
| chunkDone | output | 1 | One-cycle pulse at a chunk end |
| codeValid | output | 1 | Held parity is valid |
| parityWord | output | 22 | Held parity of the last completed chunk |
| codeBytes | output | 24 | Spare-area form of the held parity |

## Verification
The hardest states to reach from the ports are the odd alignments of the byte count. Examples are a clear that lands in the middle of a chunk in the same cycle as a valid byte, and a long run of strobes with the enable low just before the 256th byte. The stimulus builds these states on purpose. It stops one byte short of a boundary, sends ignored bytes, then issues a clear together with a byte. A behavioural model that keeps the accepted bytes in a queue checks, on every cycle, that the chunk boundary and the parity land where only the accepted bytes say they should.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  typedef struct packed {
    logic accept;
    logic clear;
    logic wrap;
  } eccStrobe_t;
endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 256,
  localparam int IDX_W = $clog2(CHUNK_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             eccEn,
  input  logic             clrPulse,
  input  logic             byteValid,
  output eccStrobe_t       strobes,
  output logic [IDX_W-1:0] byteIdx,
  output logic             chunkDone,
  output logic             codeValid
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHUNK_BYTES - 1);

  logic [IDX_W-1:0] count;

  always_comb begin
    strobes.clear  = clrPulse;
    strobes.accept = byteValid && eccEn && !clrPulse;
    strobes.wrap   = strobes.accept && (count == LAST_IDX);
  end

  assign byteIdx = count;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      chunkDone <= 1'b0;
      codeValid <= 1'b0;
    end else if (strobes.clear) begin
      count     <= '0;
      chunkDone <= 1'b0;
      codeValid <= 1'b0;
    end else begin
      chunkDone <= strobes.wrap;
      if (strobes.accept) count <= count + 1'b1;
      if (strobes.wrap) codeValid <= 1'b1;
    end
  end
endmodule

// File: rtl/nand_ecc_dp.sv
module nand_ecc_dp
  import nand_ecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 256,
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(CHUNK_BYTES),
  localparam int COL_PAIRS = $clog2(BYTE_W),
  localparam int COL_W = 2 * COL_PAIRS,
  localparam int LINE_W = 2 * IDX_W,
  localparam int PAR_W = LINE_W + COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  eccStrobe_t        strobes,
  input  logic [IDX_W-1:0]  byteIdx,
  input  logic [BYTE_W-1:0] byteData,
  output logic [PAR_W-1:0]  parityWord
);
  logic [LINE_W-1:0] lineAcc, lineNext;
  logic [BYTE_W-1:0] colAcc, colNext;
  logic [COL_W-1:0]  colPar;
  logic              bytePar;

  assign bytePar = ^byteData;
  assign colNext = colAcc ^ byteData;

  for (genvar k = 0; k < IDX_W; k++) begin : g_line
    assign lineNext[2*k]   = lineAcc[2*k]   ^ (bytePar & ~byteIdx[k]);
    assign lineNext[2*k+1] = lineAcc[2*k+1] ^ (bytePar &  byteIdx[k]);
  end

  always_comb begin
    colPar = '0;
    for (int b = 0; b < BYTE_W; b++) begin
      for (int j = 0; j < COL_PAIRS; j++) begin
        if (((b >> j) & 1) != 0) colPar[2*j+1] = colPar[2*j+1] ^ colNext[b];
        else                     colPar[2*j]   = colPar[2*j]   ^ colNext[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineAcc    <= '0;
      colAcc     <= '0;
      parityWord <= '0;
    end else if (strobes.clear) begin
      lineAcc <= '0;
      colAcc  <= '0;
    end else if (strobes.accept) begin
      if (strobes.wrap) begin
        lineAcc    <= '0;
        colAcc     <= '0;
        parityWord <= {lineNext, colPar};
      end else begin
        lineAcc <= lineNext;
        colAcc  <= colNext;
      end
    end
  end
endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
  import nand_ecc_pkg::*;
#(
  parameter int CHUNK_BYTES = 256,
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(CHUNK_BYTES),
  localparam int PAR_W = 2 * IDX_W + 2 * $clog2(BYTE_W),
  localparam int CODE_W = PAR_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eccEn,
  input  logic              clrPulse,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  output logic              chunkDone,
  output logic              codeValid,
  output logic [PAR_W-1:0]  parityWord,
  output logic [CODE_W-1:0] codeBytes
);
  eccStrobe_t       strobes;
  logic [IDX_W-1:0] byteIdx;

  nand_ecc_ctrl #(.CHUNK_BYTES(CHUNK_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .eccEn(eccEn), .clrPulse(clrPulse),
    .byteValid(byteValid), .strobes(strobes), .byteIdx(byteIdx),
    .chunkDone(chunkDone), .codeValid(codeValid)
  );

  nand_ecc_dp #(.CHUNK_BYTES(CHUNK_BYTES), .BYTE_W(BYTE_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteIdx(byteIdx),
    .byteData(byteData), .parityWord(parityWord)
  );

  // Stored form: shifted left by two, inverted; first stored byte on top.
  assign codeBytes = ~{parityWord, 2'b00};
endmodule

// File: rtl/nand_ecc_accum_chk.sv
module nand_ecc_accum_chk #(
  parameter int PAR_W = 22
) (
  input logic             clk,
  input logic             rstN,
  input logic             eccEn,
  input logic             clrPulse,
  input logic             byteValid,
  input logic             chunkDone,
  input logic             codeValid,
  input logic [PAR_W-1:0] parityWord
);
  p_done_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    chunkDone |=> !chunkDone);

  p_done_needs_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(byteValid && eccEn) |=> !chunkDone);

  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
    clrPulse |=> (!codeValid && !chunkDone));

  p_clear_keeps_word_r7: assert property (@(posedge clk) disable iff (!rstN)
    clrPulse |=> $stable(parityWord));

  p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(codeValid) |-> chunkDone);

  p_done_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    chunkDone |-> codeValid);

  p_word_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !chunkDone |-> $stable(parityWord));
endmodule

bind nand_ecc_accum nand_ecc_accum_chk #(.PAR_W(PAR_W)) chk_i (
  .clk(clk), .rstN(rstN), .eccEn(eccEn), .clrPulse(clrPulse),
  .byteValid(byteValid), .chunkDone(chunkDone), .codeValid(codeValid),
  .parityWord(parityWord)
);

// File: tb/nand_ecc_accum_tb_top.sv
module nand_ecc_accum_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eccEn = 1'b0, clrPulse = 1'b0, byteValid = 1'b0;
  logic [7:0] byteData = 8'h00;
  logic chunkDone, codeValid;
  logic [21:0] parityWord;
  logic [23:0] codeBytes;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  nand_ecc_accum dut_i (
    .clk(clk), .rstN(rstN), .eccEn(eccEn), .clrPulse(clrPulse),
    .byteValid(byteValid), .byteData(byteData), .chunkDone(chunkDone),
    .codeValid(codeValid), .parityWord(parityWord), .codeBytes(codeBytes)
  );

  // Behavioural reference model
  byte unsigned q[$];
  bit mDone = 0, mValid = 0;
  int unsigned mPar = 0;

  function automatic int unsigned chunkParity(byte unsigned bytesIn[$]);
    int unsigned p = 0;
    for (int i = 0; i < bytesIn.size(); i++) begin
      bit bp = ^bytesIn[i];
      for (int k = 0; k < 8; k++)
        if (bp) p ^= (((i >> k) & 1) != 0) ? (1 << (7 + 2*k)) : (1 << (6 + 2*k));
      for (int b = 0; b < 8; b++)
        if (bytesIn[i][b])
          for (int j = 0; j < 3; j++)
            p ^= (((b >> j) & 1) != 0) ? (1 << (2*j + 1)) : (1 << (2*j));
    end
    return p;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); mDone = 0; mValid = 0; mPar = 0;
    end else if (clrPulse) begin
      q.delete(); mDone = 0; mValid = 0;
    end else begin
      mDone = 0;
      if (byteValid && eccEn) begin
        q.push_back(byteData);
        if (q.size() == 256) begin
          mPar = chunkParity(q);
          mDone = 1; mValid = 1;
          q.delete();
        end
      end
    end
  end

  task automatic check(bit ok, string tag, int unsigned act, int unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check(chunkDone == mDone, "R3 chunkDone", chunkDone, mDone);
    check(codeValid == mValid, "R9 codeValid", codeValid, mValid);
    check(parityWord == mPar[21:0], "R6 parityWord", parityWord, mPar);
    check(codeBytes == (~(mPar << 2) & 24'hFFFFFF), "R8 codeBytes",
          codeBytes, ~(mPar << 2) & 24'hFFFFFF);
  endtask

  task automatic step(bit v, bit en, bit clr, logic [7:0] d);
    @(negedge clk);
    if (rstN) compareAll();
    byteValid = v; eccEn = en; clrPulse = clr; byteData = d;
  endtask

  task automatic sendBytes(int n, int seed, int gapEvery);
    for (int i = 0; i < n; i++) begin
      if (gapEvery != 0 && (i % gapEvery) == 0) begin
        step(1'b1, 1'b0, 1'b0, 8'hA5);   // R2: strobe without enable
        step(1'b0, 1'b1, 1'b0, 8'h3C);   // R2: enable without strobe
      end
      step(1'b1, 1'b1, 1'b0, 8'((i * 37 + seed) ^ (i >> 3) ^ (seed * 11)));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(parityWord == 0 && !chunkDone && !codeValid, "R1 reset",
          {codeValid, chunkDone, 8'h0, parityWord}, 0);
    rstN = 1'b1;
    step(1'b0, 1'b0, 1'b0, 8'h00);

    // All-zero chunk
    for (int i = 0; i < 256; i++) step(1'b1, 1'b1, 1'b0, 8'h00);
    step(1'b0, 1'b1, 1'b0, 8'h00);
    check(chunkDone && parityWord == 0 && codeBytes == 24'hFFFFFF,
          "R8 zero chunk", codeBytes, 24'hFFFFFF);

    // Single bit 0 of byte 0: all even line/column bits
    step(1'b1, 1'b1, 1'b0, 8'h01);
    for (int i = 1; i < 256; i++) step(1'b1, 1'b1, 1'b0, 8'h00);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    check(parityWord[5:0] == 6'h15, "R4 col even", parityWord[5:0], 6'h15);
    check(parityWord == 22'h155555, "R5 line even", parityWord, 22'h155555);
    check(codeBytes[23:16] == 8'hAA && codeBytes[7:0] == 8'hAB, "R8 byte order",
          codeBytes, 24'hAAAAAB);

    // Single bit 7 of byte 255: all odd bits
    for (int i = 0; i < 255; i++) step(1'b1, 1'b1, 1'b0, 8'h00);
    step(1'b1, 1'b1, 1'b0, 8'h80);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    check(parityWord[5:0] == 6'h2A, "R4 col odd", parityWord[5:0], 6'h2A);
    check(parityWord == 22'h2AAAAA, "R5 line odd", parityWord, 22'h2AAAAA);
    check(codeBytes == 24'h555557, "R8 odd code", codeBytes, 24'h555557);

    // Patterned chunks back to back with gaps
    sendBytes(256, 3, 17);
    sendBytes(256, 91, 0);
    step(1'b0, 1'b0, 1'b0, 8'h00);

    // R2: stop one short of the boundary, then send ignored bytes
    sendBytes(255, 7, 0);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 8'hFF);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    check(!chunkDone, "R2 ignored bytes", chunkDone, 0);

    // R7: clear together with a byte, mid chunk
    step(1'b1, 1'b1, 1'b1, 8'h77);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    check(!codeValid && parityWord == mPar[21:0], "R7 clear", codeValid, 0);
    sendBytes(255, 5, 0);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    check(!chunkDone && !codeValid, "R7 count restarted", chunkDone, 0);
    sendBytes(1, 9, 0);
    step(1'b0, 1'b0, 1'b0, 8'h00);
    check(chunkDone && codeValid, "R7 boundary after clear", chunkDone, 1);
    sendBytes(256, 42, 5);
    repeat (3) step(1'b0, 1'b0, 1'b0, 8'h00);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule